// File: doc/BRIEF.md
# BCD Time-of-Day Counter

This block keeps the time of day as six binary-coded decimal digits: ones and tens of seconds, of minutes and of hours. It runs from a single fast system clock, 1 MHz by default. An internal prescaler counts that clock and raises a strobe for one cycle each second. All six digit registers sample on the rising clock edge. A digit moves only in a cycle where the strobe is high and every digit below it sits at its terminal value. The time therefore advances by exactly one second per strobe. A digit never runs away while a lower digit rests at 9 between strobes.

A synchronous, active-low clear takes priority over everything else. On any rising edge where the clear is low, all digits go to zero and the prescaler restarts. The strobe is also driven onto an output, so that surrounding logic or a test environment can align itself to the second boundary. Display decoding, time setting and alarms sit outside this block.

Top module: `tod_counter`

## Requirements
- R1: On every rising edge with `clr_n` low, all six digits become 0 and the prescaler count returns to 0. This holds even when `sec_tick` is high in that cycle.
- R2: `sec_tick` is high for exactly one cycle out of every TICK_LIMIT+1 cycles. It is first high in the cycle that follows the TICK_LIMIT-th rising edge after the last edge with `clr_n` low.
- R3: In a cycle where `sec_tick` is low, no digit output changes at the following edge.
- R4: On each edge that ends a `sec_tick` cycle, the seconds-ones digit increments by one. From 9 it wraps to 0.
- R5: The seconds-tens digit (range 0 to 5) advances only on a tick edge where seconds-ones is 9. When seconds-tens is 5 at such an edge, it wraps to 0.
- R6: The minutes field advances by one on a tick edge where the seconds read 59. Minutes-ones counts 0 to 9, minutes-tens counts 0 to 5, and minutes wrap from 59 to 00.
- R7: The hours field advances on a tick edge where minutes and seconds read 59:59. It counts 00 to 23, and 23:59:59 becomes 00:00:00.
- R8: Every digit output is an unsigned binary value on 4 bits and always stays in range. Seconds-ones and minutes-ones are at most 9, seconds-tens and minutes-tens at most 5, hours-tens at most 2, and hours-ones at most 3 while hours-tens is 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (1 MHz by default) |
| clr_n | input | 1 | Synchronous active-low clear of digits and prescaler |
| sec_tick | output | 1 | One-cycle strobe, once per second |
| sec_ones | output | 4 | Seconds, ones digit |
| sec_tens | output | 4 | Seconds, tens digit |
| min_ones | output | 4 | Minutes, ones digit |
| min_tens | output | 4 | Minutes, tens digit |
| hr_ones | output | 4 | Hours, ones digit |
| hr_tens | output | 4 | Hours, tens digit |

## Verification
The embedded assertions check local rules on every cycle:
- each digit holds when it is not stepped, stays within its range, and increments or wraps correctly when stepped;
- the strobe never lasts two cycles and the prescaler count stays within its limit;
- a clear zeroes every digit;
- the 23-to-00 hour wrap lands on zero.

The bench's scenarios show whole-chain behaviour that no single-digit property covers:
- the exact strobe spacing after a clear is released;
- carries rippling across several fields in one edge (09 to 10 s, 59 s to one minute, 59:59 to one hour, and the full-day wrap);
- clears that land on a strobe cycle.

// File: rtl/tod_pkg.sv
// Package: shared digit type and field limits for the time-of-day counter.
// Assumes every digit fits in 4 bits, holding a plain binary value 0..9.
package tod_pkg;

    localparam int DIGIT_W = 4;

    typedef logic [DIGIT_W-1:0] bcd_t;

    // Terminal values of each digit position
    localparam int ONES_MAX     = 9;
    localparam int TENS60_MAX   = 5;
    localparam int HR_TENS_MAX  = 2;
    localparam int HR_ONES_LAST = 3;  // hours-ones wraps here when tens is at its max

    // Number of sixty-count fields (seconds, minutes)
    localparam int N_SIXTY = 2;

endpackage

// File: rtl/tick_gen.sv
// Module: tick_gen
// Divides the system clock down to a one-cycle strobe, issued every
// TICK_LIMIT+1 cycles. Assumes TICK_LIMIT >= 1. The synchronous active-low
// clear restarts the count at zero.
module tick_gen #(
    parameter int unsigned TICK_LIMIT = 999_999
) (
    input  logic clk,
    input  logic clr_n,
    output logic tick
);

    localparam int CW = (TICK_LIMIT < 2) ? 1 : $clog2(TICK_LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(TICK_LIMIT);

    logic [CW-1:0] cnt;

    // Free-running count from 0 to LAST, restarted by the clear
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Strobe while the count sits at its terminal value
    always_comb begin
        tick = (cnt == LAST);
    end

    // R2
    tick_single_chk: assert property (@(posedge clk) disable iff (!clr_n)
        tick |=> !tick);

    // R2
    cnt_limit_chk: assert property (@(posedge clk) disable iff (!clr_n)
        cnt <= LAST);

endmodule

// File: rtl/bcd_digit.sv
// Module: bcd_digit
// One decimal digit register. It advances by one when step is high and wraps
// to zero at MAX_VAL, or earlier when force_wrap is high. carry is high when
// the digit wraps on a step. Priority: clear, then step, then terminal value.
module bcd_digit
    import tod_pkg::*;
#(
    parameter int MAX_VAL = 9
) (
    input  logic clk,
    input  logic clr_n,
    input  logic step,
    input  logic force_wrap,
    output bcd_t q,
    output logic carry
);

    localparam bcd_t LAST = bcd_t'(MAX_VAL);

    logic at_wrap;

    // Wrap condition: natural terminal value or an early wrap from outside
    always_comb begin
        at_wrap = (q == LAST) || force_wrap;
        carry   = step && at_wrap;
    end

    // Digit register with clear > step > terminal-value priority
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            q <= '0;
        end else if (step) begin
            if (at_wrap) begin
                q <= '0;
            end else begin
                q <= q + 1'b1;
            end
        end
    end

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
        !step |=> $stable(q));

    // R8
    range_chk: assert property (@(posedge clk) disable iff (!clr_n)
        q <= LAST);

    // R4
    incr_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (step && (q != LAST) && !force_wrap) |=> (q == $past(q) + 1'b1));

    // R5
    wrap_chk: assert property (@(posedge clk) disable iff (!clr_n)
        carry |=> (q == '0));

endmodule

// File: rtl/sixty_field.sv
// Module: sixty_field
// A two-digit 00..59 field, used for seconds and for minutes. step advances
// the field by one. carry is high on the step that wraps 59 to 00.
module sixty_field
    import tod_pkg::*;
(
    input  logic clk,
    input  logic clr_n,
    input  logic step,
    output bcd_t ones,
    output bcd_t tens,
    output logic carry
);

    logic ones_carry;

    // Ones digit, 0..9
    bcd_digit #(.MAX_VAL(ONES_MAX)) u_ones (
        .clk        (clk),
        .clr_n      (clr_n),
        .step       (step),
        .force_wrap (1'b0),
        .q          (ones),
        .carry      (ones_carry)
    );

    // Tens digit, 0..5, stepped only by the ones wrap
    bcd_digit #(.MAX_VAL(TENS60_MAX)) u_tens (
        .clk        (clk),
        .clr_n      (clr_n),
        .step       (ones_carry),
        .force_wrap (1'b0),
        .q          (tens),
        .carry      (carry)
    );

    // R5
    tens_gate_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (ones != bcd_t'(ONES_MAX)) |=> $stable(tens));

endmodule

// File: rtl/hour_field.sv
// Module: hour_field
// The two-digit 00..23 hours field. step advances it by one hour. The ones
// digit wraps early at 3 when the tens digit is 2, and the field then wraps
// from 23 to 00.
module hour_field
    import tod_pkg::*;
(
    input  logic clk,
    input  logic clr_n,
    input  logic step,
    output bcd_t ones,
    output bcd_t tens
);

    logic ones_carry;
    logic tens_carry;
    logic day_end;

    // Early wrap of the ones digit at hour 23
    always_comb begin
        day_end = (tens == bcd_t'(HR_TENS_MAX)) && (ones == bcd_t'(HR_ONES_LAST));
    end

    // Hours ones digit, 0..9 or 0..3 in the twenties
    bcd_digit #(.MAX_VAL(ONES_MAX)) u_ones (
        .clk        (clk),
        .clr_n      (clr_n),
        .step       (step),
        .force_wrap (day_end),
        .q          (ones),
        .carry      (ones_carry)
    );

    // Hours tens digit, 0..2
    bcd_digit #(.MAX_VAL(HR_TENS_MAX)) u_tens (
        .clk        (clk),
        .clr_n      (clr_n),
        .step       (ones_carry),
        .force_wrap (1'b0),
        .q          (tens),
        .carry      (tens_carry)
    );

    // R7
    day_wrap_chk: assert property (@(posedge clk) disable iff (!clr_n)
        tens_carry |=> ((tens == '0) && (ones == '0)));

    // R8
    hour_range_chk: assert property (@(posedge clk) disable iff (!clr_n)
        (tens == bcd_t'(HR_TENS_MAX)) |-> (ones <= bcd_t'(HR_ONES_LAST)));

endmodule

// File: rtl/tod_counter.sv
// Module: tod_counter
// Time-of-day counter: a prescaler strobe drives a carry chain of two
// sixty-count fields (seconds, minutes) and one hours field. Every carry is
// gated by the strobe. The synchronous active-low clear zeroes all of it.
module tod_counter
    import tod_pkg::*;
#(
    parameter int unsigned TICK_LIMIT = 999_999
) (
    input  logic clk,
    input  logic clr_n,
    output logic sec_tick,
    output bcd_t sec_ones,
    output bcd_t sec_tens,
    output bcd_t min_ones,
    output bcd_t min_tens,
    output bcd_t hr_ones,
    output bcd_t hr_tens
);

    logic [N_SIXTY:0] chain;
    bcd_t             f_ones [N_SIXTY];
    bcd_t             f_tens [N_SIXTY];

    // One-second strobe
    tick_gen #(.TICK_LIMIT(TICK_LIMIT)) u_tick (
        .clk   (clk),
        .clr_n (clr_n),
        .tick  (sec_tick)
    );

    // The strobe feeds the bottom of the carry chain
    always_comb begin
        chain[0] = sec_tick;
    end

    // Seconds and minutes fields, each stepped by the carry of the one below
    for (genvar i = 0; i < N_SIXTY; i++) begin : g_sixty
        sixty_field u_field (
            .clk   (clk),
            .clr_n (clr_n),
            .step  (chain[i]),
            .ones  (f_ones[i]),
            .tens  (f_tens[i]),
            .carry (chain[i+1])
        );
    end

    // Hours field, stepped by the minute wrap
    hour_field u_hours (
        .clk   (clk),
        .clr_n (clr_n),
        .step  (chain[N_SIXTY]),
        .ones  (hr_ones),
        .tens  (hr_tens)
    );

    // Map the field array onto the named outputs
    always_comb begin
        sec_ones = f_ones[0];
        sec_tens = f_tens[0];
        min_ones = f_ones[1];
        min_tens = f_tens[1];
    end

    // R1
    clear_chk: assert property (@(posedge clk)
        !clr_n |=> ((sec_ones == '0) && (sec_tens == '0) && (min_ones == '0) &&
                    (min_tens == '0) && (hr_ones == '0) && (hr_tens == '0)));

    // R3
    quiet_chk: assert property (@(posedge clk) disable iff (!clr_n)
        !sec_tick |=> ($stable(sec_ones) && $stable(min_ones) && $stable(hr_ones)));

endmodule

// File: tb/tb_tod_counter.sv
// Testbench for tod_counter. It uses a short prescaler, random clears with a
// fixed seed, then a full simulated day, and checks the outputs each cycle
// against a model of the time and the strobe.
module tb_tod_counter;

    localparam int          CLK_PERIOD = 10;
    localparam int unsigned LIMIT      = 1;
    localparam int          SEED       = 32'h5eed_0c1c;
    localparam int          WATCHDOG   = 199_000;

    logic       clk = 1'b0;
    logic       clr_n = 1'b0;
    logic       sec_tick;
    logic [3:0] sec_ones, sec_tens, min_ones, min_tens, hr_ones, hr_tens;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // Model state, valid after the most recent rising edge
    int m_h = 0, m_m = 0, m_s = 0;
    int m_pcnt = 0;
    string tag = "R1";

    tod_counter #(.TICK_LIMIT(LIMIT)) dut (
        .clk      (clk),
        .clr_n    (clr_n),
        .sec_tick (sec_tick),
        .sec_ones (sec_ones),
        .sec_tens (sec_tens),
        .min_ones (min_ones),
        .min_tens (min_tens),
        .hr_ones  (hr_ones),
        .hr_tens  (hr_tens)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string rq, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    function automatic int in_range(input int o_s1, o_s10, o_m1, o_m10, o_h1, o_h10);
        return int'(o_s1 <= 9 && o_s10 <= 5 && o_m1 <= 9 && o_m10 <= 5 &&
                    o_h10 <= 2 && (o_h10 < 2 || o_h1 <= 3));
    endfunction

    // Requirement that a tick edge exercises, chosen from the time before it
    function automatic string tick_tag(input int h, input int m, input int s);
        if (s == 59 && m == 59) return "R7";
        if (s == 59)            return "R6";
        if (s % 10 == 9)        return "R5";
        return "R4";
    endfunction

    task automatic compare_all();
        chk(tag, "sec_ones", int'(sec_ones), m_s % 10);
        chk(tag, "sec_tens", int'(sec_tens), m_s / 10);
        chk(tag, "min_ones", int'(min_ones), m_m % 10);
        chk(tag, "min_tens", int'(min_tens), m_m / 10);
        chk(tag, "hr_ones",  int'(hr_ones),  m_h % 10);
        chk(tag, "hr_tens",  int'(hr_tens),  m_h / 10);
        chk("R2", "sec_tick", int'(sec_tick), int'(m_pcnt == int'(LIMIT)));
        chk("R8", "range", in_range(int'(sec_ones), int'(sec_tens), int'(min_ones),
                                    int'(min_tens), int'(hr_ones), int'(hr_tens)), 1);
    endtask

    // Advance the model over the next edge, given the clear applied there
    task automatic step_model();
        if (!clr_n) begin
            m_h = 0; m_m = 0; m_s = 0; m_pcnt = 0;
            tag = "R1";
        end else if (m_pcnt == int'(LIMIT)) begin
            tag = tick_tag(m_h, m_m, m_s);
            m_pcnt = 0;
            m_s++;
            if (m_s == 60) begin m_s = 0; m_m++; end
            if (m_m == 60) begin m_m = 0; m_h++; end
            if (m_h == 24) begin m_h = 0; end
        end else begin
            m_pcnt++;
            tag = "R3";
        end
    endtask

    initial begin
        int unsigned r;
        r = $urandom(SEED);
        clr_n = 1'b0;
        // Reset state after the first clear edge (R1)
        @(posedge clk);
        @(negedge clk);
        tag = "R1";
        compare_all();
        @(negedge clk);
        compare_all();
        // Phase A: random clears, some landing on strobe cycles (R1, R2, R3)
        for (int i = 0; i < 3000; i++) begin
            r = $urandom;
            clr_n = (r % 37 == 0) ? 1'b0 : 1'b1;
            step_model();
            @(negedge clk);
            compare_all();
        end
        // Directed: clear held exactly on a strobe cycle (R1)
        while (m_pcnt != int'(LIMIT)) begin
            clr_n = 1'b1;
            step_model();
            @(negedge clk);
            compare_all();
        end
        clr_n = 1'b0;
        step_model();
        @(negedge clk);
        compare_all();
        // Phase B: a full day plus margin (R4, R5, R6, R7 rollovers)
        for (int i = 0; i < 86_400 * int'(LIMIT + 1) + 40; i++) begin
            clr_n = 1'b1;
            step_model();
            @(negedge clk);
            compare_all();
        end
        // After the day wrap the hours must be back to 00 (R7)
        chk("R7", "hours after day", int'(hr_tens) * 10 + int'(hr_ones), 0);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Watchdog: ends a hung run as a failure
    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule